// File: doc/BRIEF.md
# Misaligned Physical Access Policy Checker

This block sits in a load/store unit beside the address path. For every data access it receives the operation class, the starting physical address, the access size and the attributes of the regions that hold the first and the last byte. From these it decides whether the access may go ahead as a single indivisible transfer, go ahead as a split transfer with no atomicity promise, or must raise an access exception. The region lookup and the memory are outside the block. The caller supplies a region identifier for each end and a flag that tells whether that region can perform misaligned accesses atomically.

An access is misaligned when its start address is not a whole multiple of its size. Aligned accesses of a known class skip every policy check. A misaligned access is first classified by whether both ends fall in the same region. Plain loads and stores are then treated differently from read-modify-write atomics, load-reserved and store-conditional. Two elaboration parameters set the policy. The first decides what a load or store that crosses a region boundary does. The second decides whether atomics inside a region that supports misaligned atomicity are executed or refused. The decision is registered and comes out one cycle after the request, marked by a result strobe, together with the address of the last byte.

Top module: `misalign_policy_top`

## Requirements
- R1: A result strobe `rspValid` is high in exactly the cycle after a cycle with `reqValid` high. In any cycle where `rspValid` is low, all four decision outputs are low.
- R2: Whenever `rspValid` is high, exactly one of `rspFault`, `rspAtomic` and `rspSplit` is high.
- R3: The size code `reqSizeLog2` gives 1, 2, 4 or 8 bytes for the values 0 to 3. An access is misaligned when the start address modulo the size is nonzero. An aligned access of a known class gives `rspAtomic`, whatever the region inputs are.
- R4: `rspLastAddr` equals the start address plus size minus one, modulo 2^ADDR_W. It is valid together with `rspValid`.
- R5: A misaligned load or store whose two ends carry the same region identifier, with both atomicity flags set, gives `rspAtomic`.
- R6: A misaligned read-modify-write atomic, LR or SC in such a region gives `rspAtomic` when `RMW_ATOMIC_OK` is 1, and `rspFault` when it is 0.
- R7: If the region identifiers are equal but either atomicity flag is clear, a misaligned load or store gives `rspSplit`, and a misaligned atomic, LR or SC gives `rspFault`.
- R8: If the region identifiers differ, a misaligned atomic, LR or SC gives `rspFault`, whatever the policy parameters are.
- R9: A misaligned load or store with different region identifiers follows `SPAN_POLICY`. SPAN_FAULT (0) gives `rspFault`. SPAN_SPLIT (1) gives `rspSplit`. SPAN_PARTIAL (2) gives `rspFault` with `rspNoWriteback`.
- R10: `rspNoWriteback` is high only for the region-spanning partial-completion case of R9, and never without `rspFault`.
- R11: The class codes are load 0, store 1, atomic 2, LR 3 and SC 4. Codes 5 to 7 give `rspFault` whatever the alignment.
- R12: During and right after reset, `rspValid` and all decision outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Operation class code |
| reqAddr | input | ADDR_W | Start physical address |
| reqSizeLog2 | input | 2 | log2 of the access size in bytes |
| firstRegion | input | REGION_W | Region identifier of the first byte |
| firstMisAtomic | input | 1 | First-byte region supports misaligned atomicity |
| lastRegion | input | REGION_W | Region identifier of the last byte |
| lastMisAtomic | input | 1 | Last-byte region supports misaligned atomicity |
| rspValid | output | 1 | Decision valid |
| rspFault | output | 1 | Raise access exception |
| rspAtomic | output | 1 | Proceed as an indivisible access |
| rspSplit | output | 1 | Proceed without atomicity guarantee |
| rspNoWriteback | output | 1 | Partial completion, suppress register writeback |
| rspLastAddr | output | ADDR_W | Address of the last byte |

## Verification
Three instances, each built with a different span policy and atomic setting, see the same stimulus. This shows which outputs depend on a parameter and which do not. Aligned accesses are sent with region inputs that would fail if they were misaligned, so the alignment bypass can be told apart from region classification. Misaligned requests cover all four region situations: same region with atomicity, same region without it, equal identifiers with only one flag set, and different regions. Each situation is crossed with plain and atomic classes, which separates the load/store policy from the atomic policy. Unknown class codes and an access whose last byte wraps past the top of the address space test the decoding and the address arithmetic.

// File: rtl/misalign_pkg.sv
package misalign_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_AMO   = 3'd2,
    OP_LR    = 3'd3,
    OP_SC    = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SPAN_FAULT   = 2'd0,
    SPAN_SPLIT   = 2'd1,
    SPAN_PARTIAL = 2'd2
  } span_pol_e;

  // Facts extracted by the datapath for the control
  typedef struct packed {
    logic opKnown;
    logic isRmw;
    logic misaligned;
    logic sameRegion;
    logic capable;
  } class_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic fault;
    logic atomic;
    logic split;
    logic noWb;
  } ctrl_t;

endpackage

// File: rtl/misalign_datapath.sv
module misalign_datapath
  import misalign_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int REGION_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSizeLog2,
  input  logic [REGION_W-1:0] firstRegion,
  input  logic                firstMisAtomic,
  input  logic [REGION_W-1:0] lastRegion,
  input  logic                lastMisAtomic,
  output class_t              cls,
  input  ctrl_t               ctrl,
  output logic                rspValid,
  output logic                rspFault,
  output logic                rspAtomic,
  output logic                rspSplit,
  output logic                rspNoWriteback,
  output logic [ADDR_W-1:0]   rspLastAddr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] sizeBytes;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] lastAddr;

  always_comb begin
    sizeBytes = ONE << reqSizeLog2;
    lowMask   = sizeBytes - ONE;
    lastAddr  = reqAddr + lowMask;
  end

  always_comb begin
    cls.opKnown    = (reqOp <= 3'(OP_SC));
    cls.isRmw      = (reqOp == 3'(OP_AMO)) || (reqOp == 3'(OP_LR)) || (reqOp == 3'(OP_SC));
    cls.misaligned = |(reqAddr & lowMask);
    cls.sameRegion = (firstRegion == lastRegion);
    cls.capable    = firstMisAtomic & lastMisAtomic;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid       <= 1'b0;
      rspFault       <= 1'b0;
      rspAtomic      <= 1'b0;
      rspSplit       <= 1'b0;
      rspNoWriteback <= 1'b0;
      rspLastAddr    <= '0;
    end else begin
      rspValid       <= ctrl.capture;
      rspFault       <= ctrl.capture & ctrl.fault;
      rspAtomic      <= ctrl.capture & ctrl.atomic;
      rspSplit       <= ctrl.capture & ctrl.split;
      rspNoWriteback <= ctrl.capture & ctrl.noWb;
      if (ctrl.capture) rspLastAddr <= lastAddr;
    end
  end

endmodule

// File: rtl/misalign_control.sv
module misalign_control
  import misalign_pkg::*;
#(
  parameter span_pol_e SPAN_POLICY   = SPAN_FAULT,
  parameter bit        RMW_ATOMIC_OK = 1'b1
) (
  input  logic   reqValid,
  input  class_t cls,
  output ctrl_t  ctrl
);

  // {fault, atomic, split, noWb}
  localparam logic [3:0] D_FAULT  = 4'b1000;
  localparam logic [3:0] D_ATOMIC = 4'b0100;
  localparam logic [3:0] D_SPLIT  = 4'b0010;
  localparam logic [3:0] D_PART   = 4'b1001;

  logic [3:0] spanLs;
  logic [3:0] rmwCapable;
  logic [3:0] decision;

  generate
    if (SPAN_POLICY == SPAN_SPLIT) begin : g_span_split
      assign spanLs = D_SPLIT;
    end else if (SPAN_POLICY == SPAN_PARTIAL) begin : g_span_partial
      assign spanLs = D_PART;
    end else begin : g_span_fault
      assign spanLs = D_FAULT;
    end
    if (RMW_ATOMIC_OK) begin : g_rmw_ok
      assign rmwCapable = D_ATOMIC;
    end else begin : g_rmw_refuse
      assign rmwCapable = D_FAULT;
    end
  endgenerate

  always_comb begin
    if (!cls.opKnown)         decision = D_FAULT;
    else if (!cls.misaligned) decision = D_ATOMIC;
    else if (cls.sameRegion) begin
      if (cls.capable) decision = cls.isRmw ? rmwCapable : D_ATOMIC;
      else             decision = cls.isRmw ? D_FAULT : D_SPLIT;
    end else           decision = cls.isRmw ? D_FAULT : spanLs;
  end

  always_comb begin
    ctrl.capture = reqValid;
    ctrl.fault   = decision[3];
    ctrl.atomic  = decision[2];
    ctrl.split   = decision[1];
    ctrl.noWb    = decision[0];
  end

endmodule

// File: rtl/misalign_policy_top.sv
module misalign_policy_top
  import misalign_pkg::*;
#(
  parameter int        ADDR_W        = 40,
  parameter int        REGION_W      = 6,
  parameter span_pol_e SPAN_POLICY   = SPAN_FAULT,
  parameter bit        RMW_ATOMIC_OK = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  input  logic [2:0]          reqOp,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSizeLog2,
  input  logic [REGION_W-1:0] firstRegion,
  input  logic                firstMisAtomic,
  input  logic [REGION_W-1:0] lastRegion,
  input  logic                lastMisAtomic,
  output logic                rspValid,
  output logic                rspFault,
  output logic                rspAtomic,
  output logic                rspSplit,
  output logic                rspNoWriteback,
  output logic [ADDR_W-1:0]   rspLastAddr
);

  class_t cls;
  ctrl_t  ctrl;

  misalign_datapath #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqSizeLog2(reqSizeLog2),
    .firstRegion(firstRegion), .firstMisAtomic(firstMisAtomic),
    .lastRegion(lastRegion), .lastMisAtomic(lastMisAtomic),
    .cls(cls), .ctrl(ctrl),
    .rspValid(rspValid), .rspFault(rspFault), .rspAtomic(rspAtomic),
    .rspSplit(rspSplit), .rspNoWriteback(rspNoWriteback),
    .rspLastAddr(rspLastAddr)
  );

  misalign_control #(.SPAN_POLICY(SPAN_POLICY), .RMW_ATOMIC_OK(RMW_ATOMIC_OK)) ctl_i (
    .reqValid(reqValid), .cls(cls), .ctrl(ctrl)
  );

endmodule

// File: rtl/misalign_policy_sva.sv
module misalign_policy_sva #(
  parameter int ADDR_W   = 40,
  parameter int REGION_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic [2:0]          reqOp,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [1:0]          reqSizeLog2,
  input logic [REGION_W-1:0] firstRegion,
  input logic [REGION_W-1:0] lastRegion,
  input logic                rspValid,
  input logic                rspFault,
  input logic                rspAtomic,
  input logic                rspSplit,
  input logic                rspNoWriteback,
  input logic [ADDR_W-1:0]   rspLastAddr
);

  logic [ADDR_W-1:0] span;
  logic              aligned;
  logic              rmwOp;
  always_comb begin
    span    = (ADDR_W'(1) << reqSizeLog2) - ADDR_W'(1);
    aligned = (reqAddr & span) == '0;
    rmwOp   = (reqOp >= 3'd2) && (reqOp <= 3'd4);
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> !(rspFault || rspAtomic || rspSplit || rspNoWriteback));
  p_one_decision_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> $countones({rspFault, rspAtomic, rspSplit}) == 1);
  p_aligned_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && aligned && reqOp <= 3'd4) |=> rspAtomic);
  p_last_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspLastAddr == $past(reqAddr) + $past(span));
  p_rmw_span_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && rmwOp && !aligned && firstRegion != lastRegion) |=> rspFault);
  p_nowb_needs_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rspNoWriteback |-> rspFault);
  p_bad_op_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqOp > 3'd4) |=> (rspFault && !rspNoWriteback));

endmodule

bind misalign_policy_top misalign_policy_sva #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .reqSizeLog2(reqSizeLog2), .firstRegion(firstRegion), .lastRegion(lastRegion),
  .rspValid(rspValid), .rspFault(rspFault), .rspAtomic(rspAtomic), .rspSplit(rspSplit),
  .rspNoWriteback(rspNoWriteback), .rspLastAddr(rspLastAddr)
);

// File: tb/misalign_policy_top_tb_top.sv
`timescale 1ns/1ps
module misalign_policy_top_tb_top;
  import misalign_pkg::*;

  localparam int ADDR_W   = 40;
  localparam int REGION_W = 6;
  localparam int NDUT     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                reqValid = 1'b0;
  logic [2:0]          reqOp = '0;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [1:0]          reqSizeLog2 = '0;
  logic [REGION_W-1:0] firstRegion = '0;
  logic                firstMisAtomic = 1'b0;
  logic [REGION_W-1:0] lastRegion = '0;
  logic                lastMisAtomic = 1'b0;

  logic              vld  [NDUT];
  logic [3:0]        flg  [NDUT];
  logic [ADDR_W-1:0] last [NDUT];

  // per-instance policy: 0 partial/rmw ok, 1 split/rmw refused, 2 fault/rmw ok
  int  polOf [NDUT] = '{2, 1, 0};
  bit  rmwOf [NDUT] = '{1'b1, 1'b0, 1'b1};

  misalign_policy_top #(.ADDR_W(ADDR_W), .REGION_W(REGION_W),
    .SPAN_POLICY(SPAN_PARTIAL), .RMW_ATOMIC_OK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSizeLog2(reqSizeLog2), .firstRegion(firstRegion), .firstMisAtomic(firstMisAtomic),
    .lastRegion(lastRegion), .lastMisAtomic(lastMisAtomic), .rspValid(vld[0]),
    .rspFault(flg[0][3]), .rspAtomic(flg[0][2]), .rspSplit(flg[0][1]),
    .rspNoWriteback(flg[0][0]), .rspLastAddr(last[0]));

  misalign_policy_top #(.ADDR_W(ADDR_W), .REGION_W(REGION_W),
    .SPAN_POLICY(SPAN_SPLIT), .RMW_ATOMIC_OK(1'b0)) dutB_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSizeLog2(reqSizeLog2), .firstRegion(firstRegion), .firstMisAtomic(firstMisAtomic),
    .lastRegion(lastRegion), .lastMisAtomic(lastMisAtomic), .rspValid(vld[1]),
    .rspFault(flg[1][3]), .rspAtomic(flg[1][2]), .rspSplit(flg[1][1]),
    .rspNoWriteback(flg[1][0]), .rspLastAddr(last[1]));

  misalign_policy_top #(.ADDR_W(ADDR_W), .REGION_W(REGION_W),
    .SPAN_POLICY(SPAN_FAULT), .RMW_ATOMIC_OK(1'b1)) dutC_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqSizeLog2(reqSizeLog2), .firstRegion(firstRegion), .firstMisAtomic(firstMisAtomic),
    .lastRegion(lastRegion), .lastMisAtomic(lastMisAtomic), .rspValid(vld[2]),
    .rspFault(flg[2][3]), .rspAtomic(flg[2][2]), .rspSplit(flg[2][1]),
    .rspNoWriteback(flg[2][0]), .rspLastAddr(last[2]));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Expected decision {fault, atomic, split, noWb}, from the requirements
  function automatic logic [3:0] expFlags(input logic [2:0] op, input logic [ADDR_W-1:0] addr,
      input logic [1:0] szl, input logic [REGION_W-1:0] fr, input logic fa,
      input logic [REGION_W-1:0] lr, input logic la, input int pol, input bit rmwOk);
    longint unsigned size = 64'd1 << szl;
    bit mis = (addr % size) != 0;
    bit rmw = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
    if (op > 3'd4) return 4'b1000;           // R11
    if (!mis) return 4'b0100;                // R3
    if (fr == lr) begin
      if (fa && la) return rmw ? (rmwOk ? 4'b0100 : 4'b1000) : 4'b0100; // R5 R6
      return rmw ? 4'b1000 : 4'b0010;        // R7
    end
    if (rmw) return 4'b1000;                 // R8
    if (pol == 0) return 4'b1000;            // R9
    if (pol == 1) return 4'b0010;
    return 4'b1001;                          // R9 R10
  endfunction

  task automatic doReq(input string req, input logic [2:0] op, input logic [ADDR_W-1:0] addr,
      input logic [1:0] szl, input logic [REGION_W-1:0] fr, input logic fa,
      input logic [REGION_W-1:0] lr, input logic la);
    logic [ADDR_W-1:0] expLast;
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqSizeLog2 = szl;
    firstRegion = fr; firstMisAtomic = fa; lastRegion = lr; lastMisAtomic = la;
    expLast = addr + (ADDR_W'(1) << szl) - ADDR_W'(1);
    @(negedge clk);
    reqValid = 1'b0;
    for (int d = 0; d < NDUT; d++) begin
      check("R1", $sformatf("dut%0d valid", d), 64'(vld[d]), 64'd1);
      check(req, $sformatf("dut%0d flags", d), 64'(flg[d]),
            64'(expFlags(op, addr, szl, fr, fa, lr, la, polOf[d], rmwOf[d])));
      check("R2", $sformatf("dut%0d one decision", d),
            64'($countones(flg[d][3:1])), 64'd1);
      check("R4", $sformatf("dut%0d last addr", d), 64'(last[d]), 64'(expLast));
    end
    @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      check("R1", $sformatf("dut%0d idle", d), 64'({vld[d], flg[d]}), 64'd0);
    end
  endtask

  task automatic testReset();
    for (int d = 0; d < NDUT; d++)
      check("R12", $sformatf("dut%0d reset", d), 64'({vld[d], flg[d]}), 64'd0);
  endtask

  task automatic testAligned();
    // R3: aligned, regions hostile, still atomic
    doReq("R3", 3'd0, 40'h1000, 2'd3, 6'd1, 1'b0, 6'd2, 1'b0);
    doReq("R3", 3'd2, 40'h20,   2'd2, 6'd1, 1'b0, 6'd2, 1'b0);
    doReq("R3", 3'd1, 40'h333,  2'd0, 6'd3, 1'b0, 6'd4, 1'b0);
  endtask

  task automatic testSameCapable();
    doReq("R5", 3'd0, 40'h1003, 2'd2, 6'd5, 1'b1, 6'd5, 1'b1);
    doReq("R6", 3'd2, 40'h2006, 2'd3, 6'd5, 1'b1, 6'd5, 1'b1);
    doReq("R6", 3'd4, 40'h2001, 2'd1, 6'd5, 1'b1, 6'd5, 1'b1);
  endtask

  task automatic testSameNoAtomic();
    doReq("R7", 3'd1, 40'h3005, 2'd2, 6'd7, 1'b0, 6'd7, 1'b0);
    doReq("R7", 3'd3, 40'h3005, 2'd2, 6'd7, 1'b0, 6'd7, 1'b0);
    doReq("R7", 3'd0, 40'h3002, 2'd3, 6'd7, 1'b1, 6'd7, 1'b0);
  endtask

  task automatic testSpanning();
    doReq("R8", 3'd4, 40'h4ffe, 2'd2, 6'd8, 1'b1, 6'd9, 1'b1);
    doReq("R8", 3'd2, 40'h4ffd, 2'd3, 6'd8, 1'b1, 6'd9, 1'b1);
    doReq("R9", 3'd0, 40'h4fff, 2'd1, 6'd8, 1'b1, 6'd9, 1'b1);
    doReq("R10", 3'd1, 40'h4ffc, 2'd3, 6'd8, 1'b0, 6'd9, 1'b0);
  endtask

  task automatic testUnknownOp();
    doReq("R11", 3'd6, 40'h100, 2'd2, 6'd1, 1'b1, 6'd1, 1'b1);
    doReq("R11", 3'd5, 40'h101, 2'd2, 6'd1, 1'b1, 6'd2, 1'b1);
  endtask

  task automatic testWrap();
    doReq("R4", 3'd0, {ADDR_W{1'b1}} - 40'd2, 2'd3, 6'd10, 1'b1, 6'd10, 1'b1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testAligned();
    testSameCapable();
    testSameNoAtomic();
    testSpanning();
    testUnknownOp();
    testWrap();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

endmodule